// File: doc/BRIEF.md
# Serial Programming Target Controller

This block is the target side of a three-wire serial programming link. An external host drives the serial clock and the serial data input. The block answers on the serial data output. Through this link the host can read, erase and write two memories that sit outside the block: a word-wide program memory and a byte-wide data EEPROM. The link is live only while the programming reset input `prog_rst_n` is held low. Driving that input high abandons any half-received instruction and also withdraws the unlock.

The serial clock is not used as a clock. The system clock samples it through a synchronizer whose depth is set by a parameter, and an edge detector turns the synchronized level into rising and falling events. Every instruction is four bytes long and is sent most significant bit first. While the host shifts a byte in, the block shifts the previous byte back out, so the host can confirm that the two ends are in step. The one exception is the fourth byte of a read, which carries the addressed memory byte. Program memory writes, EEPROM writes and the chip erase each raise an internal busy window of fixed length. During that window only read instructions are acted on.

Top module: `isp_target_ctrl`

## Requirements
- R1: While `prog_rst_n` is high, `miso` is low and no memory strobe fires. Raising `prog_rst_n` part way through an instruction discards the partial frame and clears the unlock. The next frame received after `prog_rst_n` goes low again starts at its first bit.
- R2: After each low-going `prog_rst_n`, the block ignores every instruction until an unlock has been accepted. Erase, load, commit and EEPROM write produce no strobe. A read returns its third byte in place of memory data.
- R3: The unlock instruction is 0xAC, 0x53, any, any. During each byte after the first, `miso` carries the byte received just before it, so the third byte of the unlock echoes 0x53.
- R4: `mosi` is taken on the rising serial-clock edge and `miso` changes only after a falling edge, most significant bit first, in frames of exactly four bytes.
- R5: Chip erase, 0xAC, 0x80, any, any, gives one single-cycle `chip_erase` pulse. The memories then read 0xFF everywhere.
- R6: EEPROM write, 0xC0, addr_hi, addr_lo, data, gives one `ee_write` pulse. `ee_addr` is the low `EE_AW` bits of {addr_hi, addr_lo} and `ee_wdata` is the data byte. No prior erase is needed: reading the location back returns the new byte.
- R7: Page load, 0x40 (low byte) or 0x48 (high byte), addr_hi, addr_lo, data, gives one `pm_load` pulse. `pm_hi` equals opcode bit 3. Commit, 0x4C, any, any, any, gives one `pm_commit` pulse, and the loaded words then read back.
- R8: Program memory reads, 0x20 (low byte) or 0x28 (high byte), and EEPROM read, 0xA0, each followed by addr_hi and addr_lo, return the addressed byte during the fourth byte.
- R9: Commit, EEPROM write and chip erase each start a busy window of `BUSY_CYCLES` clocks. Within it, non-read instructions produce no strobe, while reads are still answered.
- R10: Once the busy window has expired, write-type instructions are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| prog_rst_n | input | 1 | Programming reset; the link is live while low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| pm_addr | output | PMEM_AW | Program memory word address |
| pm_hi | output | 1 | Selects the high byte of the program word |
| pm_wdata | output | 8 | Byte to load into the program page buffer |
| pm_load | output | 1 | Page-buffer load strobe |
| pm_commit | output | 1 | Page commit strobe |
| pm_rdata | input | 8 | Program memory read byte (combinational) |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_write | output | 1 | EEPROM self-erasing write strobe |
| ee_rdata | input | 8 | EEPROM read byte (combinational) |
| chip_erase | output | 1 | Erase strobe covering both memories |

## Verification
The bench builds the block with `MIN_PHASE` = 3, which selects the deeper three-stage synchronizer. This makes the path from a host edge to a `miso` change as long as it can be, so holding each serial-clock phase for eight clocks exercises the worst-case turnaround. `PMEM_AW` = 8 and `EE_AW` = 7 keep the bench memory models small. `BUSY_CYCLES` = 1200 is longer than two back-to-back instructions, so an instruction sent straight after a write lands inside the busy window. An idle gap of 1300 clocks then shows the window expiring.

// File: rtl/isp_pkg.sv
package isp_pkg;
   localparam logic [7:0] OP_PREFIX    = 8'hAC;
   localparam logic [7:0] OP_UNLOCK    = 8'h53;
   localparam logic [7:0] OP_ERASE     = 8'h80;
   localparam logic [7:0] OP_PM_RD_LO  = 8'h20;
   localparam logic [7:0] OP_PM_RD_HI  = 8'h28;
   localparam logic [7:0] OP_PM_LD_LO  = 8'h40;
   localparam logic [7:0] OP_PM_LD_HI  = 8'h48;
   localparam logic [7:0] OP_PM_COMMIT = 8'h4C;
   localparam logic [7:0] OP_EE_RD     = 8'hA0;
   localparam logic [7:0] OP_EE_WR     = 8'hC0;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_UNLOCK, CMD_ERASE, CMD_PM_LOAD,
      CMD_PM_COMMIT, CMD_EE_WRITE, CMD_READ
   } isp_cmd_e;

   function automatic isp_cmd_e isp_decode(input logic [7:0] op, input logic [7:0] sub);
      isp_cmd_e c;
      c = CMD_NONE;
      if (op == OP_PREFIX && sub == OP_UNLOCK)                 c = CMD_UNLOCK;
      else if (op == OP_PREFIX && sub == OP_ERASE)             c = CMD_ERASE;
      else if (op == OP_PM_LD_LO || op == OP_PM_LD_HI)         c = CMD_PM_LOAD;
      else if (op == OP_PM_COMMIT)                             c = CMD_PM_COMMIT;
      else if (op == OP_EE_WR)                                 c = CMD_EE_WRITE;
      else if (op == OP_PM_RD_LO || op == OP_PM_RD_HI || op == OP_EE_RD) c = CMD_READ;
      return c;
   endfunction

   function automatic logic isp_is_read(input logic [7:0] op);
      return (op == OP_PM_RD_LO) || (op == OP_PM_RD_HI) || (op == OP_EE_RD);
   endfunction
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
   parameter int            DEPTH = 2,
   parameter int            W     = 1,
   parameter logic [W-1:0]  INIT  = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [DEPTH];

   initial begin
      assert (DEPTH >= 2) else $error("isp_sync: DEPTH must be at least 2");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) stg[i] <= INIT;
            else         stg[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) stg[i] <= INIT;
            else         stg[i] <= stg[i-1];
      end
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            active,
   input  logic            sck_s,
   input  logic            mosi_s,
   input  logic            alt_en,
   input  logic [7:0]      alt_data,
   output logic [3:0][7:0] frame,
   output logic            frame_done,
   output logic            miso
);
   logic       sck_d;
   logic [4:0] bitc;
   logic [7:0] rx;
   logic [7:0] tx;
   logic       fresh;
   logic [1:0] done_idx;

   wire       rise  = active &&  sck_s && !sck_d;
   wire       fall  = active && !sck_s &&  sck_d;
   wire [7:0] rx_nx = {rx[6:0], mosi_s};
   wire [7:0] src   = (done_idx == 2'd2 && alt_en) ? alt_data : frame[done_idx];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sck_d <= 1'b0; bitc <= '0; rx <= '0; tx <= '0; fresh <= 1'b0;
         done_idx <= '0; frame <= '0; frame_done <= 1'b0; miso <= 1'b0;
      end else begin
         sck_d      <= sck_s;
         frame_done <= 1'b0;
         if (!active) begin
            bitc <= '0; rx <= '0; tx <= '0; fresh <= 1'b0; miso <= 1'b0;
         end else if (rise) begin
            rx   <= rx_nx;
            bitc <= bitc + 5'd1;
            if (bitc[2:0] == 3'd7) begin
               frame[bitc[4:3]] <= rx_nx;
               done_idx         <= bitc[4:3];
               fresh            <= 1'b1;
               if (bitc[4:3] == 2'd3) frame_done <= 1'b1;
            end
         end else if (fall) begin
            if (fresh) begin
               miso  <= src[7];
               tx    <= {src[6:0], 1'b0};
               fresh <= 1'b0;
            end else begin
               miso <= tx[7];
               tx   <= {tx[6:0], 1'b0};
            end
         end
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!arst_n)
      !active |=> (bitc == 5'd0 && !miso));
   p_miso_after_fall_r4: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(miso) |-> ($past(fall) || $past(!active)));
endmodule

// File: rtl/isp_exec.sv
module isp_exec
   import isp_pkg::*;
#(
   parameter int BUSY_CYCLES = 64
) (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            active,
   input  logic            frame_done,
   input  logic [3:0][7:0] frame,
   output logic            unlocked,
   output logic            busy,
   output logic            chip_erase,
   output logic            pm_load,
   output logic            pm_commit,
   output logic            ee_write
);
   localparam int BW = $clog2(BUSY_CYCLES + 1);

   logic [BW-1:0] cnt;
   isp_cmd_e      cmd;
   logic          go;

   assign busy = (cnt != '0);
   assign cmd  = isp_decode(frame[0], frame[1]);
   assign go   = unlocked && !busy;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         unlocked <= 1'b0; cnt <= '0;
         chip_erase <= 1'b0; pm_load <= 1'b0; pm_commit <= 1'b0; ee_write <= 1'b0;
      end else begin
         chip_erase <= 1'b0; pm_load <= 1'b0; pm_commit <= 1'b0; ee_write <= 1'b0;
         if (!active) begin
            unlocked <= 1'b0;
            cnt      <= '0;
         end else begin
            if (busy) cnt <= cnt - 1'b1;
            if (frame_done) begin
               unique case (cmd)
                  CMD_UNLOCK:    unlocked <= 1'b1;
                  CMD_ERASE:     if (go) begin chip_erase <= 1'b1; cnt <= BW'(BUSY_CYCLES); end
                  CMD_PM_LOAD:   if (go) pm_load <= 1'b1;
                  CMD_PM_COMMIT: if (go) begin pm_commit <= 1'b1; cnt <= BW'(BUSY_CYCLES); end
                  CMD_EE_WRITE:  if (go) begin ee_write <= 1'b1; cnt <= BW'(BUSY_CYCLES); end
                  default: ;
               endcase
            end
         end
      end
   end

   p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0({chip_erase, pm_load, pm_commit, ee_write}));
   p_locked_no_strobe_r2: assert property (@(posedge clk) disable iff (!arst_n)
      (chip_erase || pm_load || pm_commit || ee_write) |-> $past(unlocked));
   p_write_sets_busy_r9: assert property (@(posedge clk) disable iff (!arst_n)
      (chip_erase || pm_commit || ee_write) |-> busy);
   p_busy_bound_r9: assert property (@(posedge clk) disable iff (!arst_n)
      cnt <= BW'(BUSY_CYCLES));
   p_inactive_no_strobe_r1: assert property (@(posedge clk) disable iff (!arst_n)
      !active |=> !(chip_erase || pm_load || pm_commit || ee_write));
endmodule

// File: rtl/isp_target_ctrl.sv
module isp_target_ctrl
   import isp_pkg::*;
#(
   parameter int PMEM_AW     = 10,
   parameter int EE_AW       = 7,
   parameter int BUSY_CYCLES = 64,
   parameter int MIN_PHASE   = 2
) (
   input  logic               clk,
   input  logic               arst_n,
   input  logic               prog_rst_n,
   input  logic               sck,
   input  logic               mosi,
   output logic               miso,
   output logic [PMEM_AW-1:0] pm_addr,
   output logic               pm_hi,
   output logic [7:0]         pm_wdata,
   output logic               pm_load,
   output logic               pm_commit,
   input  logic [7:0]         pm_rdata,
   output logic [EE_AW-1:0]   ee_addr,
   output logic [7:0]         ee_wdata,
   output logic               ee_write,
   input  logic [7:0]         ee_rdata,
   output logic               chip_erase
);
   localparam int SYNC_DEPTH = (MIN_PHASE >= 3) ? 3 : 2;

   initial begin
      assert (MIN_PHASE == 2 || MIN_PHASE == 3) else $error("MIN_PHASE must be 2 or 3");
      assert (PMEM_AW >= 1 && PMEM_AW <= 16)    else $error("PMEM_AW out of range");
      assert (EE_AW >= 1 && EE_AW <= 16)        else $error("EE_AW out of range");
      assert (BUSY_CYCLES >= 1)                 else $error("BUSY_CYCLES must be positive");
   end

   logic [2:0]      sync_q;
   logic            active;
   logic [3:0][7:0] frame;
   logic            frame_done;
   logic            unlocked;
   logic            busy;
   logic            alt_en;
   logic [7:0]      alt_data;
   logic [15:0]     word_addr;

   isp_sync #(.DEPTH(SYNC_DEPTH), .W(3), .INIT(3'b100)) u_sync (
      .clk(clk), .arst_n(arst_n), .d({prog_rst_n, sck, mosi}), .q(sync_q));

   assign active = !sync_q[2];

   assign alt_en   = unlocked && isp_is_read(frame[0]);
   assign alt_data = (frame[0] == OP_EE_RD) ? ee_rdata : pm_rdata;

   isp_shifter u_shift (
      .clk(clk), .arst_n(arst_n), .active(active), .sck_s(sync_q[1]), .mosi_s(sync_q[0]),
      .alt_en(alt_en), .alt_data(alt_data), .frame(frame), .frame_done(frame_done),
      .miso(miso));

   isp_exec #(.BUSY_CYCLES(BUSY_CYCLES)) u_exec (
      .clk(clk), .arst_n(arst_n), .active(active), .frame_done(frame_done), .frame(frame),
      .unlocked(unlocked), .busy(busy), .chip_erase(chip_erase), .pm_load(pm_load),
      .pm_commit(pm_commit), .ee_write(ee_write));

   assign word_addr = {frame[1], frame[2]};
   assign pm_addr   = word_addr[PMEM_AW-1:0];
   assign pm_hi     = frame[0][3];
   assign pm_wdata  = frame[3];
   assign ee_addr   = word_addr[EE_AW-1:0];
   assign ee_wdata  = frame[3];
endmodule

// File: tb/isp_target_ctrl_test.sv
module isp_target_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int PH         = 8;
   localparam int PAW        = 8;
   localparam int EAW        = 7;
   localparam int BUSY       = 1200;

   logic clk = 1'b0;
   logic arst_n = 1'b0, prog_rst_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso, pm_hi, pm_load, pm_commit, ee_write, chip_erase;
   logic [PAW-1:0] pm_addr;
   logic [EAW-1:0] ee_addr;
   logic [7:0] pm_wdata, ee_wdata, pm_rdata, ee_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   isp_target_ctrl #(.PMEM_AW(PAW), .EE_AW(EAW), .BUSY_CYCLES(BUSY), .MIN_PHASE(3)) uut (
      .clk(clk), .arst_n(arst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
      .miso(miso), .pm_addr(pm_addr), .pm_hi(pm_hi), .pm_wdata(pm_wdata),
      .pm_load(pm_load), .pm_commit(pm_commit), .pm_rdata(pm_rdata), .ee_addr(ee_addr),
      .ee_wdata(ee_wdata), .ee_write(ee_write), .ee_rdata(ee_rdata), .chip_erase(chip_erase));

   // behavioural memories
   logic [15:0] pm   [2**PAW];
   logic [15:0] pbuf [2**PAW];
   logic        pval [2**PAW];
   logic [7:0]  ee   [2**EAW];
   int n_ce = 0, n_ld = 0, n_cm = 0, n_ew = 0;
   logic [EAW-1:0] last_ee_addr = '0;
   logic [7:0]     last_ee_data = '0;

   initial begin
      for (int i = 0; i < 2**PAW; i++) begin
         pm[i] = 16'(16'h1000 + i*3); pbuf[i] = 16'hFFFF; pval[i] = 1'b0;
      end
      for (int i = 0; i < 2**EAW; i++) ee[i] = 8'(i) ^ 8'h5A;
   end

   always @(posedge clk) begin
      if (chip_erase) begin
         n_ce++;
         for (int i = 0; i < 2**PAW; i++) pm[i] = 16'hFFFF;
         for (int i = 0; i < 2**EAW; i++) ee[i] = 8'hFF;
      end
      if (ee_write) begin
         n_ew++; ee[ee_addr] = ee_wdata; last_ee_addr = ee_addr; last_ee_data = ee_wdata;
      end
      if (pm_load) begin
         n_ld++;
         if (pm_hi) pbuf[pm_addr][15:8] = pm_wdata; else pbuf[pm_addr][7:0] = pm_wdata;
         pval[pm_addr] = 1'b1;
      end
      if (pm_commit) begin
         n_cm++;
         for (int i = 0; i < 2**PAW; i++)
            if (pval[i]) begin pm[i] = pbuf[i]; pval[i] = 1'b0; pbuf[i] = 16'hFFFF; end
      end
   end

   assign pm_rdata = pm_hi ? pm[pm_addr][15:8] : pm[pm_addr][7:0];
   assign ee_rdata = ee[ee_addr];

   // scoreboard
   typedef struct {
      logic [7:0] e2; logic [7:0] e3; logic [7:0] e4; string t3; string t4;
   } exp_t;
   exp_t q[$];
   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   int          mcnt = 0;
   logic [31:0] resp = '0;
   exp_t        it;
   always @(posedge sck or posedge prog_rst_n) begin
      if (prog_rst_n) mcnt = 0;
      else begin
         resp = {resp[30:0], miso};
         mcnt++;
         if (mcnt == 32) begin
            mcnt = 0;
            if (q.size() == 0) chk(1'b0, "R4 unexpected frame", resp, 0);
            else begin
               it = q.pop_front();
               chk(resp[23:16] == it.e2, "R4 second byte echoes first", 32'(resp[23:16]), 32'(it.e2));
               chk(resp[15:8]  == it.e3, it.t3, 32'(resp[15:8]), 32'(it.e3));
               chk(resp[7:0]   == it.e4, it.t4, 32'(resp[7:0]),  32'(it.e4));
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i]; tick(PH); sck = 1'b1; tick(PH); sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] b0, b1, b2, b3, e4, input string t4);
      exp_t e;
      e.e2 = b0; e.e3 = b1; e.e4 = e4; e.t3 = "R3 third byte echoes second"; e.t4 = t4;
      q.push_back(e);
      send_byte(b0); send_byte(b1); send_byte(b2); send_byte(b3);
      tick(PH);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      tick(5); arst_n = 1'b1; tick(5);
      chk(miso == 1'b0, "R1 reset miso", 32'(miso), 0);
      chk(n_ce + n_ld + n_cm + n_ew == 0, "R1 no strobes at reset", 32'(n_ce + n_ld + n_cm + n_ew), 0);
      prog_rst_n = 1'b0; tick(10);

      xfer(8'hC0, 8'h00, 8'h05, 8'h5A, 8'h05, "R2 locked write echo");
      chk(n_ew == 0, "R2 locked ee write ignored", 32'(n_ew), 0);
      xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, "R2 locked erase echo");
      chk(n_ce == 0, "R2 locked erase ignored", 32'(n_ce), 0);
      xfer(8'hA0, 8'h00, 8'h05, 8'h00, 8'h05, "R2 locked read echoes byte three");

      xfer(8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, "R3 unlock fourth byte");
      xfer(8'hA0, 8'h00, 8'h05, 8'h00, 8'h5F, "R8 ee read");
      xfer(8'h28, 8'h00, 8'h03, 8'h00, 8'h10, "R8 pm read high");
      xfer(8'h20, 8'h00, 8'h03, 8'h00, 8'h09, "R8 pm read low");

      xfer(8'hC0, 8'h00, 8'h05, 8'hA7, 8'h05, "R6 write echo");
      chk(n_ew == 1, "R6 ee write strobe", 32'(n_ew), 1);
      chk(last_ee_addr == 7'd5 && last_ee_data == 8'hA7, "R6 ee addr/data",
          {16'h0, 1'b0, last_ee_addr, last_ee_data}, 32'h05A7);
      xfer(8'hC0, 8'h00, 8'h06, 8'h11, 8'h06, "R9 write echo while busy");
      chk(n_ew == 1, "R9 write ignored while busy", 32'(n_ew), 1);
      xfer(8'hA0, 8'h00, 8'h06, 8'h00, 8'h5C, "R9 read answered while busy");
      xfer(8'hA0, 8'h00, 8'h05, 8'h00, 8'hA7, "R6 readback without erase");

      tick(BUSY + 100);
      xfer(8'hC0, 8'h00, 8'h06, 8'h11, 8'h06, "R10 write echo");
      chk(n_ew == 2, "R10 write accepted after busy", 32'(n_ew), 2);
      xfer(8'hA0, 8'h00, 8'h06, 8'h00, 8'h11, "R10 readback");

      tick(BUSY + 100);
      xfer(8'h40, 8'h00, 8'h03, 8'h34, 8'h03, "R7 load low echo");
      xfer(8'h48, 8'h00, 8'h03, 8'h12, 8'h03, "R7 load high echo");
      chk(n_ld == 2, "R7 two load strobes", 32'(n_ld), 2);
      xfer(8'h4C, 8'h00, 8'h00, 8'h00, 8'h00, "R7 commit echo");
      chk(n_cm == 1, "R7 commit strobe", 32'(n_cm), 1);
      xfer(8'h20, 8'h00, 8'h03, 8'h00, 8'h34, "R7 committed low byte");
      xfer(8'h28, 8'h00, 8'h03, 8'h00, 8'h12, "R7 committed high byte");

      tick(BUSY + 100);
      xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, "R5 erase echo");
      chk(n_ce == 1, "R5 erase strobe", 32'(n_ce), 1);
      xfer(8'h28, 8'h00, 8'h03, 8'h00, 8'hFF, "R5 pm erased");
      xfer(8'hA0, 8'h00, 8'h06, 8'h00, 8'hFF, "R5 ee erased");

      tick(BUSY + 100);
      send_byte(8'hC0); send_byte(8'h00);
      prog_rst_n = 1'b1; tick(20);
      chk(miso == 1'b0, "R1 miso low when released", 32'(miso), 0);
      prog_rst_n = 1'b0; tick(10);
      xfer(8'hC0, 8'h00, 8'h07, 8'h22, 8'h07, "R1 fresh frame after abort");
      chk(n_ew == 2, "R1 abort cleared unlock", 32'(n_ew), 2);
      xfer(8'hAC, 8'h53, 8'h00, 8'h00, 8'h00, "R3 re-unlock");
      xfer(8'hA0, 8'h00, 8'h07, 8'h00, 8'hFF, "R1 framing restarted");

      tick(20);
      chk(q.size() == 0, "R4 all frames seen", 32'(q.size()), 0);
      summary();
   end
endmodule